// File: doc/BRIEF.md
# Single-Word SPI Master

This block moves one word of a configurable width over a four-wire serial link each time it is started. A one-cycle start request in the idle state latches the parallel input word and begins a transfer. A fixed chain of phases paces the transfer. Each phase lasts one period of an internal tick, and the tick comes from a power-of-two clock divider that restarts whenever a transfer is accepted. The chain is a select set-up phase, then four phases per bit (drive, clock, drive, clock), then a select release phase and an inter-word gap. Bits leave on MOSI most-significant first. MISO is shifted into the received word once per bit.

On the user side, a ready flag shows when a new start will be taken. The clock-polarity input sets the level SCK rests at, and a select-enable input chooses whether the active-low select pin is driven for this word. The received word is complete by the start of the gap phase and stays on its output until the next accepted start. All pin-side outputs come from registers.

Top module: `spi_word_master`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `ready_o`=1, `spi_sel_n_o`=1, `spi_mosi_o`=0, `rx_word_o`=0, and `spi_sck_o` is at the idle level. Reset in the middle of a transfer abandons the transfer.
- R2: `go_i` high in the idle state is accepted on that clock edge. `ready_o` is 0 from the cycle after that edge and returns to 1 exactly (4*WORD_W+3)*(2^DIV_EXP+1) cycles after it. `ready_o` is 1 only while idle.
- R3: If `sel_en_i` is 1 at acceptance, `spi_sel_n_o` is 0 from the cycle after acceptance for (4*WORD_W+2)*(2^DIV_EXP+1) cycles, and it is 1 during the final gap phase. If `sel_en_i` is 0, `spi_sel_n_o` stays 1 for the whole transfer, and the transfer still runs.
- R4: The word latched at acceptance goes out on `spi_mosi_o` most-significant bit first, one bit per SCK pulse. The bit is stable before and during the pulse, and `spi_mosi_o` is 0 outside the bit phases.
- R5: The idle level of `spi_sck_o` is the inverse of `pol_i`. The active level is `pol_i`. Exactly WORD_W pulses occur per transfer.
- R6: MISO is sampled once per bit, at the end of the first clock phase while SCK is active, and is shifted in most-significant bit first. `rx_word_o` holds the full word from the start of the gap phase until the next accepted start.
- R7: With `spi_mosi_o` looped back to `spi_miso_i`, `rx_word_o` equals the transmitted word at the end of every transfer.
- R8: `go_i` pulses while busy, and changes on `tx_word_i` after acceptance, change neither the transfer timing nor the bits sent.
- R9: Every phase lasts 2^DIV_EXP+1 cycles, because the tick counter restarts at acceptance. The first active SCK edge appears exactly 2*(2^DIV_EXP+1) cycles after acceptance, however long the block was idle before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| go_i | input | 1 | Start request, taken only while idle |
| sel_en_i | input | 1 | Drive the select pin for this word |
| pol_i | input | 1 | SCK active level; idle level is its inverse |
| tx_word_i | input | WORD_W | Word to send, latched at acceptance |
| rx_word_o | output | WORD_W | Received word |
| ready_o | output | 1 | High while idle |
| spi_sel_n_o | output | 1 | Active-low slave select |
| spi_sck_o | output | 1 | Serial clock |
| spi_mosi_o | output | 1 | Serial data out |
| spi_miso_i | input | 1 | Serial data in |

## Verification
A wrong phase or a wrong bit count inside the sequencer shows at the ports within one transfer. It changes either the number of SCK pulses or the cycle on which `ready_o` returns, and both are checked to the exact cycle. A divider that fails to restart shifts the first active SCK edge away from its fixed offset after acceptance. A slip in the shift registers shows as a mismatch between the bits seen on MOSI at each active SCK edge and the received word read at the gap phase. Both loop-back and an independent reply pattern on MISO are used, so transmit and receive faults cannot mask each other.

// File: rtl/spi_word_pkg.sv
package spi_word_pkg;
  typedef enum logic [2:0] {
    PH_IDLE        = 3'd0,
    PH_SEL_SETUP   = 3'd1,
    PH_DRIVE_A     = 3'd2,
    PH_CLK_A       = 3'd3,
    PH_DRIVE_B     = 3'd4,
    PH_CLK_B       = 3'd5,
    PH_SEL_RELEASE = 3'd6,
    PH_GAP         = 3'd7
  } phase_t;
endpackage

// File: rtl/spi_tick_div.sv
module spi_tick_div #(
  parameter int DIV_EXP = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic restart_i,
  output logic tick_o
);
  localparam int CW = DIV_EXP + 1;

  logic [CW-1:0] cnt_q;

  assign tick_o = cnt_q[DIV_EXP];

  always_ff @(posedge clk) begin
    if (rst || restart_i || tick_o) cnt_q <= '0;
    else                            cnt_q <= cnt_q + 1'b1;
  end

  // R9: a tick never lasts two cycles, and a restart is never followed by a tick
  p_tick_single_r9: assert property (@(posedge clk) disable iff (rst)
    tick_o |=> !tick_o);
  p_restart_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    restart_i |=> !tick_o);
endmodule

// File: rtl/spi_phase_fsm.sv
module spi_phase_fsm
  import spi_word_pkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   go_i,
  input  logic   tick_i,
  output phase_t phase_o,
  output phase_t phase_next_o,
  output logic   launch_o,
  output logic   sample_o
);
  localparam int BW = $clog2(WORD_W + 1);

  phase_t        phase_q, phase_d;
  logic [BW-1:0] bits_q;

  assign launch_o     = (phase_q == PH_IDLE) && go_i;
  assign sample_o     = (phase_q == PH_CLK_A) && tick_i;
  assign phase_o      = phase_q;
  assign phase_next_o = phase_d;

  always_comb begin
    phase_d = phase_q;
    case (phase_q)
      PH_IDLE:        if (go_i)   phase_d = PH_SEL_SETUP;
      PH_SEL_SETUP:   if (tick_i) phase_d = PH_DRIVE_A;
      PH_DRIVE_A:     if (tick_i) phase_d = PH_CLK_A;
      PH_CLK_A:       if (tick_i) phase_d = PH_DRIVE_B;
      PH_DRIVE_B:     if (tick_i) phase_d = PH_CLK_B;
      PH_CLK_B:       if (tick_i) phase_d = (bits_q == BW'(WORD_W)) ? PH_SEL_RELEASE : PH_DRIVE_A;
      PH_SEL_RELEASE: if (tick_i) phase_d = PH_GAP;
      PH_GAP:         if (tick_i) phase_d = PH_IDLE;
      default:                    phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) phase_q <= PH_IDLE;
    else     phase_q <= phase_d;
  end

  always_ff @(posedge clk) begin
    if (rst || phase_q == PH_IDLE) bits_q <= '0;
    else if (sample_o)             bits_q <= bits_q + 1'b1;
  end

  // R2: accepted start enters set-up; count stays in range; phases wait for a tick
  p_launch_r2: assert property (@(posedge clk) disable iff (rst)
    launch_o |=> phase_q == PH_SEL_SETUP);
  p_bits_bound_r2: assert property (@(posedge clk) disable iff (rst)
    bits_q <= BW'(WORD_W));
  p_hold_no_tick_r9: assert property (@(posedge clk) disable iff (rst)
    (phase_q != PH_IDLE && !tick_i) |=> $stable(phase_q));
endmodule

// File: rtl/spi_shift_path.sv
module spi_shift_path
  import spi_word_pkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  phase_t            phase_i,
  input  phase_t            phase_next_i,
  input  logic              launch_i,
  input  logic              sample_i,
  input  logic [WORD_W-1:0] tx_word_i,
  input  logic              miso_i,
  output logic              mosi_o,
  output logic [WORD_W-1:0] rx_word_o
);
  logic [WORD_W-1:0] tx_q, rx_q;
  logic [WORD_W:0]   rx_cat;
  logic              mosi_q, enter_bit, in_bit;

  assign enter_bit = (phase_next_i == PH_DRIVE_A) && (phase_i != PH_DRIVE_A);
  assign in_bit    = phase_next_i inside {PH_DRIVE_A, PH_CLK_A, PH_DRIVE_B, PH_CLK_B};
  assign rx_cat    = {rx_q, miso_i};
  assign mosi_o    = mosi_q;
  assign rx_word_o = rx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_q   <= '0;
      mosi_q <= 1'b0;
    end else begin
      if (launch_i)       tx_q <= tx_word_i;
      else if (enter_bit) tx_q <= tx_q << 1;
      if (enter_bit)      mosi_q <= tx_q[WORD_W-1];
      else if (!in_bit)   mosi_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           rx_q <= '0;
    else if (sample_i) rx_q <= rx_cat[WORD_W-1:0];
  end

  // R4: MOSI quiet outside bit phases and steady within a bit
  p_mosi_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    (phase_i inside {PH_IDLE, PH_SEL_SETUP, PH_SEL_RELEASE, PH_GAP}) |-> !mosi_q);
  p_mosi_steady_r4: assert property (@(posedge clk) disable iff (rst)
    (phase_i inside {PH_CLK_A, PH_DRIVE_B, PH_CLK_B}) |-> $stable(mosi_q));
  // R6: received word is held while idle
  p_rx_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (phase_i == PH_IDLE) |=> $stable(rx_q));
endmodule

// File: rtl/spi_word_master.sv
module spi_word_master
  import spi_word_pkg::*;
#(
  parameter int WORD_W  = 8,
  parameter int DIV_EXP = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go_i,
  input  logic              sel_en_i,
  input  logic              pol_i,
  input  logic [WORD_W-1:0] tx_word_i,
  output logic [WORD_W-1:0] rx_word_o,
  output logic              ready_o,
  output logic              spi_sel_n_o,
  output logic              spi_sck_o,
  output logic              spi_mosi_o,
  input  logic              spi_miso_i
);
  phase_t phase, phase_next;
  logic   tick, launch, sample;
  logic   ready_q, sel_n_q, sck_q;

  spi_tick_div #(.DIV_EXP(DIV_EXP)) u_div (
    .clk(clk), .rst(rst), .restart_i(launch), .tick_o(tick)
  );

  spi_phase_fsm #(.WORD_W(WORD_W)) u_fsm (
    .clk(clk), .rst(rst), .go_i(go_i), .tick_i(tick),
    .phase_o(phase), .phase_next_o(phase_next),
    .launch_o(launch), .sample_o(sample)
  );

  spi_shift_path #(.WORD_W(WORD_W)) u_path (
    .clk(clk), .rst(rst), .phase_i(phase), .phase_next_i(phase_next),
    .launch_i(launch), .sample_i(sample), .tx_word_i(tx_word_i),
    .miso_i(spi_miso_i), .mosi_o(spi_mosi_o), .rx_word_o(rx_word_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ready_q <= 1'b1;
      sel_n_q <= 1'b1;
      sck_q   <= !pol_i;
    end else begin
      ready_q <= (phase_next == PH_IDLE);
      sck_q   <= (phase_next inside {PH_CLK_A, PH_DRIVE_B}) ? pol_i : !pol_i;
      if (phase_next inside {PH_IDLE, PH_GAP}) sel_n_q <= 1'b1;
      else if (launch)                         sel_n_q <= !sel_en_i;
    end
  end

  assign ready_o     = ready_q;
  assign spi_sel_n_o = sel_n_q;
  assign spi_sck_o   = sck_q;

  // R3: select released whenever idle or in the gap
  p_sel_off_idle_r3: assert property (@(posedge clk) disable iff (rst)
    ready_o |-> spi_sel_n_o);
  p_sel_off_gap_r3: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_GAP) |-> spi_sel_n_o);
  // R5: SCK rests at the inverse of the polarity input while idle
  p_sck_idle_r5: assert property (@(posedge clk) disable iff (rst)
    (ready_o && $stable(pol_i)) |-> (spi_sck_o == !pol_i));
endmodule

// File: tb/spi_word_master_bench.sv
`timescale 1ns/1ps
module spi_word_master_bench;
  localparam int W      = 8;
  localparam int E      = 2;
  localparam int P      = (1 << E) + 1;
  localparam int T      = (4 * W + 3) * P;
  localparam int GAP_AT = (4 * W + 2) * P;
  localparam int FIRST  = 2 * P;

  typedef struct packed {
    logic [7:0] tx;
    logic       en;
    logic       pol;
    logic [3:0] gap;
    logic       loopb;
    logic [7:0] rep;
    logic [7:0] busy_at;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{8'hA5, 1'b1, 1'b1, 4'd0, 1'b1, 8'h00, 8'd0},
    '{8'h3C, 1'b1, 1'b0, 4'd3, 1'b1, 8'h00, 8'd0},
    '{8'h00, 1'b0, 1'b1, 4'd5, 1'b0, 8'hC3, 8'd0},
    '{8'hFF, 1'b1, 1'b1, 4'd7, 1'b0, 8'h5A, 8'd40},
    '{8'h81, 1'b1, 1'b0, 4'd2, 1'b1, 8'h00, 8'd90},
    '{8'h6E, 1'b0, 1'b0, 4'd1, 1'b1, 8'h00, 8'd0}
  };

  logic         clk = 1'b0;
  logic         rst, go, sel_en, pol, miso;
  logic [W-1:0] tx_word, rx_word, rep;
  logic         ready, sel_n, sck, mosi, loopb;
  int           idx;
  int           total = 0;
  int           bad   = 0;

  always #5 clk = ~clk;

  assign miso = loopb ? mosi : ((idx < W) ? rep[W-1-idx] : 1'b0);

  spi_word_master #(.WORD_W(W), .DIV_EXP(E)) u_spi_word_master (
    .clk(clk), .rst(rst), .go_i(go), .sel_en_i(sel_en), .pol_i(pol),
    .tx_word_i(tx_word), .rx_word_o(rx_word), .ready_o(ready),
    .spi_sel_n_o(sel_n), .spi_sck_o(sck), .spi_mosi_o(mosi),
    .spi_miso_i(miso)
  );

  task automatic chk(input logic ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_reset_state(input string tag);
    chk(ready == 1'b1, {tag, " R1 ready"}, ready, 1);
    chk(sel_n == 1'b1, {tag, " R1 sel_n"}, sel_n, 1);
    chk(mosi == 1'b0, {tag, " R1 mosi"}, mosi, 0);
    chk(rx_word == '0, {tag, " R1 rx_word"}, rx_word, 0);
    chk(sck == !pol, {tag, " R1 sck idle"}, sck, !pol);
  endtask

  task automatic run_vec(input vec_t v);
    int       pulses, first_at, ready_err, sel_err;
    logic     prev_sck, sck_end;
    logic [W-1:0] cap, rx_gap, rx_end, exp_rx;
    pol = v.pol; sel_en = v.en; tx_word = v.tx; loopb = v.loopb; rep = v.rep; idx = 0;
    repeat (int'(v.gap) + 1) @(negedge clk);
    go = 1'b1;
    @(negedge clk);
    go = 1'b0;
    pulses = 0; first_at = -1; ready_err = 0; sel_err = 0;
    cap = '0; rx_gap = '0; rx_end = '0; sck_end = 1'b0;
    prev_sck = sck;
    for (int n = 0; n <= T; n++) begin
      if (n > 0) @(negedge clk);
      if (ready != (n == T)) ready_err++;
      if (sel_n != ((n >= GAP_AT) ? 1'b1 : !v.en)) sel_err++;
      if (sck != prev_sck) begin
        if (sck == v.pol) begin
          pulses++;
          cap = {cap[W-2:0], mosi};
          if (first_at < 0) first_at = n;
        end else begin
          idx++;
        end
      end
      prev_sck = sck;
      if (n == GAP_AT) rx_gap = rx_word;
      if (n == T) begin rx_end = rx_word; sck_end = sck; end
      if (v.busy_at != 0 && n == int'(v.busy_at)) begin go = 1'b1; tx_word = ~v.tx; end
      if (v.busy_at != 0 && n == int'(v.busy_at) + 1) go = 1'b0;
    end
    exp_rx = v.loopb ? v.tx : v.rep;
    chk(ready_err == 0, "R2/R8 ready low for exact transfer length", ready_err, 0);
    chk(sel_err == 0, "R3 select level over transfer", sel_err, 0);
    chk(first_at == FIRST, "R9 first active SCK edge offset", first_at, FIRST);
    chk(pulses == W, "R5 SCK pulse count", pulses, W);
    chk(sck_end == !v.pol, "R5 SCK idle level after transfer", sck_end, !v.pol);
    chk(cap == v.tx, "R4/R8 MOSI bits MSB first", cap, v.tx);
    chk(rx_gap == exp_rx, v.loopb ? "R7 loopback word at gap" : "R6 received word at gap", rx_gap, exp_rx);
    chk(rx_end == exp_rx, "R6 received word held at idle", rx_end, exp_rx);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1'b1; go = 1'b0; sel_en = 1'b0; pol = 1'b1; tx_word = '0;
    rep = '0; loopb = 1'b1; idx = 0;
    repeat (3) @(negedge clk);
    check_reset_state("during reset");
    rst = 1'b0;
    @(negedge clk);
    check_reset_state("after reset");

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R1: reset in the middle of a transfer
    pol = 1'b1; sel_en = 1'b1; tx_word = 8'hF0; loopb = 1'b1;
    @(negedge clk);
    go = 1'b1;
    @(negedge clk);
    go = 1'b0;
    repeat (60) @(negedge clk);
    chk(ready == 1'b0, "R2 busy before mid-transfer reset", ready, 0);
    rst = 1'b1;
    @(negedge clk);
    check_reset_state("mid-transfer reset");
    rst = 1'b0;
    @(negedge clk);
    check_reset_state("after mid-transfer reset");

    run_vec(VECS[0]);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule